// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external 128K x 8 asynchronous static RAM. The RAM has two chip selects of opposite polarity: one is active low and the other is active high. The host issues one request at a time on a valid/ready port: a write flag, a 17-bit address and a write byte. The controller turns each request into a pin-level cycle built from whole system clock periods. It drives the address, active-low write enable, active-low output enable and both chip selects. The bidirectional data bus is split into an input, an output and a driver enable. Each read returns its byte through a one-clock strobe.

Every timing limit is a parameter counted in clock cycles, each at least 1. The designer rounds the nanosecond figure up at the chosen clock period. The parameters are `T_AA_CYC` (address to valid data), `T_OE_CYC` (output enable to valid data), `T_OHZ_CYC` (bus release after output disable), `T_AS_CYC` (address setup before write enable), `T_WP_CYC` (write pulse) and `T_DH_CYC` (data hold after write enable rises).

The controller is a state machine with seven states. `ST_IDLE` holds the part in standby and is the only state in which a request is accepted. A read runs `ST_IDLE -> ST_RD_ADDR -> ST_RD_OE -> ST_RD_TURN -> ST_IDLE`. In `ST_RD_ADDR` the part is selected with both enables high, so its outputs stay high-impedance. In `ST_RD_OE` output enable is low and the byte is sampled on the last edge. In `ST_RD_TURN` the part is deselected while the bus is released. A write runs `ST_IDLE -> ST_WR_SETUP -> ST_WR_PULSE -> ST_WR_HOLD -> ST_IDLE`. Each non-idle state moves on when its phase timer reaches its last cycle. `ST_IDLE` moves on when a request is valid.

Top module: `sram_bus_ctrl`

## Requirements
- R1: A synchronous reset forces these values within one clock: `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rd_valid`=0. This holds even when the reset lands in the middle of a write pulse.
- R2: While `req_ready` is high, the RAM is held in standby (`mem_cs1_n`=1, `mem_cs2`=0) and the data drivers are off.
- R3: After a read is accepted, the part is selected with write enable and output enable high for max(1, T_AA_CYC-T_OE_CYC) cycles. Output enable is then low for T_OE_CYC cycles. The byte is sampled on the final edge, so the address has been held at least T_AA_CYC cycles.
- R4: `rd_valid` is high for exactly one clock, with the sampled byte on `rd_data`. This happens in cycle max(1,T_AA_CYC-T_OE_CYC)+T_OE_CYC+1, where cycle 1 is the first cycle after the accepting edge.
- R5: After sampling, a read deselects the part with output enable high for T_OHZ_CYC cycles. `req_ready` returns in cycle max(1,T_AA_CYC-T_OE_CYC)+T_OE_CYC+T_OHZ_CYC+1.
- R6: A write holds the address with the part selected and write enable high for T_AS_CYC cycles. It then drives write enable low for T_WP_CYC cycles. The write byte is driven during the whole low window and for T_DH_CYC cycles after it. `req_ready` returns in cycle T_AS_CYC+T_WP_CYC+T_DH_CYC+1.
- R7: The data drivers are never on while output enable is low. Write enable and output enable are never low together.
- R8: `req_ready` drops on the cycle after acceptance and stays low until the transfer ends. `mem_addr` does not change while `req_ready` is low.
- R9: A read returns the byte most recently written to that address. This holds across the full address range, including 0x00000 and 0x1FFFF, and for back-to-back reads of one address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-clock strobe for returned read byte |
| rd_data | output | 8 | Returned read byte |
| mem_addr | output | 17 | RAM address pins |
| mem_dq_in | input | 8 | Data bus as seen from the RAM |
| mem_dq_out | output | 8 | Data the controller drives onto the bus |
| mem_dq_oe | output | 1 | Controller data driver enable |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_cs1_n | output | 1 | RAM chip select, active low |
| mem_cs2 | output | 1 | RAM chip select, active high |

## Verification
The assertions watch these rules on every cycle:
- no driver/output-enable overlap and no write/output-enable overlap;
- the standby encoding while idle, and the reset values;
- the single-cycle read strobe and the busy ready signal;
- a stable address during a transfer;
- write data being driven whenever write enable is low and on the cycle it rises.

Only the bench scenarios can show the cycle counts of each phase and the read latency. The bench's RAM model returns garbage until both access deadlines have passed. The scenarios also cover read-back integrity at the ends of the address range and recovery from a reset taken mid-write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_OE,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctrl_state_e;

    // Cycles spent selected with outputs disabled before output enable falls.
    function automatic int unsigned rd_lead_cycles(input int unsigned aa, input int unsigned oe);
        return (aa > oe) ? (aa - oe) : 1;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             last
);

    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= TMR_W'(1);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt > TMR_W'(1)) begin
            cnt <= cnt - TMR_W'(1);
        end
    end

    assign last = (cnt == TMR_W'(1));

    // R3
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst) cnt != '0);

endmodule

// File: rtl/sram_xfer_regs.sv
module sram_xfer_regs #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) begin
                rdata_q <= dq_in;
            end
        end
    end

    // R4
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst) rvalid_q |=> !rvalid_q);

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int TMR_W     = 8,
    parameter int T_AA_CYC  = 3,
    parameter int T_OE_CYC  = 1,
    parameter int T_OHZ_CYC = 1,
    parameter int T_AS_CYC  = 1,
    parameter int T_WP_CYC  = 2,
    parameter int T_DH_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_cs1_n,
    output logic              mem_cs2
);

    localparam int unsigned RD_LEAD = rd_lead_cycles(T_AA_CYC, T_OE_CYC);

    ctrl_state_e      state, nxt;
    logic             phase_last;
    logic             phase_load;
    logic [TMR_W-1:0] phase_len;
    logic             accept;
    logic             capture;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid) nxt = req_write ? ST_WR_SETUP : ST_RD_ADDR;
            ST_RD_ADDR:  if (phase_last) nxt = ST_RD_OE;
            ST_RD_OE:    if (phase_last) nxt = ST_RD_TURN;
            ST_RD_TURN:  if (phase_last) nxt = ST_IDLE;
            ST_WR_SETUP: if (phase_last) nxt = ST_WR_PULSE;
            ST_WR_PULSE: if (phase_last) nxt = ST_WR_HOLD;
            ST_WR_HOLD:  if (phase_last) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Length of the phase being entered
    always_comb begin
        phase_len = TMR_W'(1);
        unique case (nxt)
            ST_RD_ADDR:  phase_len = TMR_W'(RD_LEAD);
            ST_RD_OE:    phase_len = TMR_W'(T_OE_CYC);
            ST_RD_TURN:  phase_len = TMR_W'(T_OHZ_CYC);
            ST_WR_SETUP: phase_len = TMR_W'(T_AS_CYC);
            ST_WR_PULSE: phase_len = TMR_W'(T_WP_CYC);
            ST_WR_HOLD:  phase_len = TMR_W'(T_DH_CYC);
            default:     phase_len = TMR_W'(1);
        endcase
    end

    assign phase_load = (nxt != state);
    assign req_ready  = (state == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign capture    = (state == ST_RD_OE) && phase_last;

    // Pin encodings per state
    always_comb begin
        mem_cs1_n = 1'b1;
        mem_cs2   = 1'b0;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            ST_IDLE, ST_RD_TURN: begin
            end
            ST_RD_ADDR, ST_WR_SETUP: begin
                mem_cs1_n = 1'b0;
                mem_cs2   = 1'b1;
            end
            ST_RD_OE: begin
                mem_cs1_n = 1'b0;
                mem_cs2   = 1'b1;
                mem_oe_n  = 1'b0;
            end
            ST_WR_PULSE: begin
                mem_cs1_n = 1'b0;
                mem_cs2   = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                mem_cs1_n = 1'b0;
                mem_cs2   = 1'b1;
                mem_dq_oe = 1'b1;
            end
            default: begin
            end
        endcase
    end

    sram_phase_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (phase_load),
        .load_val (phase_len),
        .last     (phase_last)
    );

    sram_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .dq_in     (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rd_data),
        .rvalid_q  (rd_valid)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rd_valid));
    // R2
    idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs1_n && !mem_cs2 && !mem_dq_oe));
    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (rst) !(mem_dq_oe && !mem_oe_n));
    // R7
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!mem_we_n && !mem_oe_n));
    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> (req_ready || $stable(mem_addr)));
    // R6
    we_data_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_dq_oe && !mem_cs1_n && mem_cs2));
    // R6
    we_rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n) |=> (!mem_we_n || mem_dq_oe));

endmodule

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;

    localparam int T_AA  = 3;
    localparam int T_OE  = 1;
    localparam int T_OHZ = 1;
    localparam int T_AS  = 1;
    localparam int T_WP  = 2;
    localparam int T_DH  = 1;
    localparam int LEAD  = (T_AA > T_OE) ? (T_AA - T_OE) : 1;
    localparam int RD_LAT = LEAD + T_OE + 1;
    localparam int RD_TOT = LEAD + T_OE + T_OHZ + 1;
    localparam int WR_TOT = T_AS + T_WP + T_DH + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_in = 8'hA5;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic        mem_cs1_n;
    logic        mem_cs2;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] model_arr [logic [16:0]];
    logic [7:0] ref_arr   [logic [16:0]];

    always #10 clk = ~clk;

    sram_bus_ctrl #(
        .T_AA_CYC(T_AA), .T_OE_CYC(T_OE), .T_OHZ_CYC(T_OHZ),
        .T_AS_CYC(T_AS), .T_WP_CYC(T_WP), .T_DH_CYC(T_DH)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_read(input logic [16:0] a);
        return ref_arr.exists(a) ? ref_arr[a] : 8'h00;
    endfunction

    // ---------------- cycle-level RAM model ----------------
    logic        selected;
    int          aa_cnt = 0;
    int          oe_cnt = 0;
    logic [16:0] last_addr = '0;
    assign selected = !mem_cs1_n && mem_cs2;

    always @(posedge clk) begin
        if (selected) aa_cnt <= (mem_addr == last_addr) ? aa_cnt + 1 : 1;
        else          aa_cnt <= 0;
        last_addr <= mem_addr;
        oe_cnt <= (selected && !mem_oe_n) ? oe_cnt + 1 : 0;
        if (selected && !mem_we_n && mem_dq_oe) model_arr[mem_addr] = mem_dq_out;
    end

    always @(negedge clk) begin
        if (selected && mem_we_n && !mem_oe_n && aa_cnt >= T_AA - 1 && oe_cnt >= T_OE - 1)
            mem_dq_in <= model_arr.exists(mem_addr) ? model_arr[mem_addr] : 8'h00;
        else
            mem_dq_in <= 8'hA5;
    end

    // ---------------- per-cycle encoding monitor ----------------
    logic prev_we_n = 1'b1;
    int   we_low  = 0;
    int   hold_left = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && !mem_oe_n) check(1'b0, "R7", "bus contention", 1, 0);
            if (!mem_we_n && !mem_oe_n) check(1'b0, "R7", "we and oe both low", 1, 0);
            if (req_ready && (!mem_cs1_n || mem_cs2 || mem_dq_oe))
                check(1'b0, "R2", "idle not in standby", {mem_cs1_n, mem_cs2, mem_dq_oe}, 3'b100);
            if (!mem_we_n && prev_we_n) check(aa_cnt >= T_AS, "R6", "address setup", aa_cnt, T_AS);
            if (!mem_we_n && !(mem_dq_oe && selected)) check(1'b0, "R6", "write window drive", mem_dq_oe, 1);
            if (hold_left > 0) begin
                check(mem_dq_oe, "R6", "data hold", mem_dq_oe, 1);
                hold_left <= hold_left - 1;
            end
            if (!mem_we_n) we_low <= we_low + 1;
            if (mem_we_n && !prev_we_n) begin
                check(we_low == T_WP, "R6", "write pulse width", we_low, T_WP);
                we_low <= 0;
                if (T_DH > 1) hold_left <= T_DH - 1;
                check(mem_dq_oe, "R6", "data hold first cycle", mem_dq_oe, 1);
            end
            prev_we_n <= mem_we_n;
        end
    end

    // ---------------- request task ----------------
    task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
        int n;
        int strobes;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        strobes = 0;
        check(!req_ready, "R8", "ready low after accept", req_ready, 0);
        while (!req_ready && n < 100) begin
            if (rd_valid) begin
                strobes++;
                check(!wr && n == RD_LAT, "R4", "read strobe cycle", n, RD_LAT);
                check(rd_data == ref_read(a), "R9", "read data", rd_data, ref_read(a));
            end
            @(negedge clk);
            n++;
        end
        if (wr) begin
            check(n == WR_TOT, "R6", "write occupancy", n, WR_TOT);
            ref_arr[a] = d;
        end else begin
            check(strobes == 1, "R4", "single read strobe", strobes, 1);
            check(n == RD_TOT, "R5", "read occupancy", n, RD_TOT);
        end
        check(!rd_valid, "R4", "strobe low at idle", rd_valid, 0);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rd_valid,
              "R1", "reset state", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        rst = 1'b0;

        // R9 directed: range ends and back-to-back reads
        do_op(1'b1, 17'h00000, 8'h3C);
        do_op(1'b1, 17'h1FFFF, 8'hC3);
        do_op(1'b0, 17'h00000, 8'h00);
        do_op(1'b0, 17'h1FFFF, 8'h00);
        do_op(1'b0, 17'h1FFFF, 8'h00);
        do_op(1'b1, 17'h1FFFF, 8'h5A);
        do_op(1'b0, 17'h1FFFF, 8'h00);

        // R3 read latency seen through R4/R5 checks; random mix
        for (int i = 0; i < 60; i++) begin
            logic [16:0] a;
            a = 17'h00100 + 17'($urandom_range(0, 15));
            do_op(1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)));
        end

        // R1 reset in the middle of a write pulse
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0AAAA; req_wdata = 8'h77;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (mem_we_n) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
              "R1", "reset mid write", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        rst = 1'b0;
        do_op(1'b0, 17'h00000, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule